// File: doc/BRIEF.md
# Boot Strap Capture and Interrupt Pin Front End

This block sits between a set of shared chip pins and the core. While the chip reset is held, three mode pins and two strap pins act only as configuration inputs. At the first clock edge after reset is released, their synchronized values are latched into an operating mode field, a PLL enable bit and a clock-output polarity bit. These values then hold until the next reset.

After that capture, two of the mode pins become interrupt inputs. Mode pin B becomes a maskable request. It is either level-sensitive or falling-edge triggered, chosen by an input. Mode pin C becomes a non-maskable request that reacts to falling edges only. Every pin passes through a multi-flop synchronizer. Edge-triggered requests are kept in sticky pending flags, and software clears them with write-one-to-clear strobes.

Top module: `strap_irq_unit`

## Requirements
- R1: At the first rising clock edge after `rstN` goes high, `opMode` captures the synchronized mode pins: bit 0 from pin A, bit 1 from pin B, bit 2 from pin C.
- R2: At that same edge, `pllEnable` captures the synchronized PLL strap and `clkOutInvert` captures the synchronized polarity strap.
- R3: After capture, `opMode`, `pllEnable` and `clkOutInvert` do not change, whatever the pins do, until reset is asserted again.
- R4: While `rstN` is low, `irqReq` and `nmiReq` are 0 and `opMode` is 0, even if the pins toggle.
- R5: Each pin passes through two synchronizer stages. In level mode, a change on pin B reaches `irqReq` at the second rising edge after the change, and not at the first.
- R6: With `irqEdgeMode` = 1, a falling edge on pin B sets `irqReq` at the third rising edge after the pin falls. `irqReq` then stays high after the pin returns high.
- R7: With `irqEdgeMode` = 0, `irqReq` is the inverse of the synchronized pin B level and latches nothing. It drops two edges after the pin rises.
- R8: A falling edge on pin C sets a sticky `nmiReq` at the third rising edge after the fall, whatever the value of `irqEdgeMode`.
- R9: `irqClr` or `nmiClr` high at a rising edge clears the matching pending flag. If a new edge sets the flag at that same rising edge, the set takes priority over the clear.
- R10: A pin B or C held low through reset release produces no edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset; its release triggers strap capture |
| modePins | input | NUM_MODE | Mode pins A (bit 0), B (bit 1), C (bit 2) |
| pllInitPin | input | 1 | PLL enable strap pin |
| clkPolPin | input | 1 | Clock output polarity strap pin |
| irqEdgeMode | input | 1 | 1: pin B falling-edge triggered, 0: level-sensitive active low |
| irqClr | input | 1 | Write-one-to-clear for the maskable pending flag |
| nmiClr | input | 1 | Write-one-to-clear for the non-maskable pending flag |
| opMode | output | NUM_MODE | Latched operating mode |
| pllEnable | output | 1 | Latched PLL enable strap |
| clkOutInvert | output | 1 | Latched clock output polarity |
| irqReq | output | 1 | Maskable interrupt request |
| nmiReq | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its defaults: three mode pins, two synchronizer stages, pin B as the maskable source and pin C as the non-maskable one. With two stages, each check can be placed on an exact edge. The level request is checked on the second edge after a pin change, the edge requests on the third, and a clear is checked on the edge where a new set arrives. Holding the pins low through reset release shows that no false edge appears when detection starts.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;
  typedef struct packed {
    logic capture;
    logic detectEn;
    logic irqSet;
    logic irqClr;
    logic nmiSet;
    logic nmiClr;
  } ctrlStb_t;
endpackage

// File: rtl/strap_irq_dp.sv
module strap_irq_dp
  import strap_irq_pkg::*;
#(
  parameter int NUM_MODE    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_IDX     = 1,
  parameter int NMI_IDX     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_MODE-1:0] modePins,
  input  logic                pllInitPin,
  input  logic                clkPolPin,
  input  logic                irqEdgeMode,
  input  ctrlStb_t            stb,
  output logic                irqNow,
  output logic                irqPrev,
  output logic                nmiNow,
  output logic                nmiPrev,
  output logic [NUM_MODE-1:0] opMode,
  output logic                pllEnable,
  output logic                clkOutInvert,
  output logic                irqReq,
  output logic                nmiReq
);
  localparam int NUM_PINS = NUM_MODE + 2;
  localparam int PLL_BIT  = NUM_MODE;
  localparam int POL_BIT  = NUM_MODE + 1;

  logic [NUM_PINS-1:0] rawPins;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncNow;
  logic irqPend, nmiPend;

  assign rawPins = {clkPolPin, pllInitPin, modePins};

  // Synchronizer chain is not reset so straps settle while reset is held
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) syncQ[s] <= rawPins;
    end else begin : g_next
      always_ff @(posedge clk) syncQ[s] <= syncQ[s-1];
    end
  end

  assign syncNow = syncQ[SYNC_STAGES-1];
  assign irqNow  = syncNow[IRQ_IDX];
  assign nmiNow  = syncNow[NMI_IDX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opMode       <= '0;
      pllEnable    <= 1'b0;
      clkOutInvert <= 1'b0;
      irqPrev      <= 1'b1;
      nmiPrev      <= 1'b1;
      irqPend      <= 1'b0;
      nmiPend      <= 1'b0;
    end else begin
      if (stb.capture) begin
        opMode       <= syncNow[NUM_MODE-1:0];
        pllEnable    <= syncNow[PLL_BIT];
        clkOutInvert <= syncNow[POL_BIT];
      end
      irqPrev <= irqNow;
      nmiPrev <= nmiNow;
      if (stb.irqSet)      irqPend <= 1'b1;
      else if (stb.irqClr) irqPend <= 1'b0;
      if (stb.nmiSet)      nmiPend <= 1'b1;
      else if (stb.nmiClr) nmiPend <= 1'b0;
    end
  end

  assign irqReq = irqEdgeMode ? irqPend : (stb.detectEn & ~irqNow);
  assign nmiReq = nmiPend;
endmodule

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl
  import strap_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     irqNow,
  input  logic     irqPrev,
  input  logic     nmiNow,
  input  logic     nmiPrev,
  input  logic     irqEdgeMode,
  input  logic     irqClrIn,
  input  logic     nmiClrIn,
  output logic     armed,
  output ctrlStb_t stb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    stb.capture  = ~armed;
    stb.detectEn = armed;
    stb.irqSet   = armed & irqEdgeMode & irqPrev & ~irqNow;
    stb.irqClr   = irqClrIn;
    stb.nmiSet   = armed & nmiPrev & ~nmiNow;
    stb.nmiClr   = nmiClrIn;
  end
endmodule

// File: rtl/strap_irq_unit.sv
module strap_irq_unit
  import strap_irq_pkg::*;
#(
  parameter int NUM_MODE    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_MODE-1:0] modePins,
  input  logic                pllInitPin,
  input  logic                clkPolPin,
  input  logic                irqEdgeMode,
  input  logic                irqClr,
  input  logic                nmiClr,
  output logic [NUM_MODE-1:0] opMode,
  output logic                pllEnable,
  output logic                clkOutInvert,
  output logic                irqReq,
  output logic                nmiReq
);
  ctrlStb_t stbW;
  logic armedW, irqNowW, irqPrevW, nmiNowW, nmiPrevW;

  strap_irq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .irqNow(irqNowW), .irqPrev(irqPrevW),
    .nmiNow(nmiNowW), .nmiPrev(nmiPrevW),
    .irqEdgeMode(irqEdgeMode), .irqClrIn(irqClr), .nmiClrIn(nmiClr),
    .armed(armedW), .stb(stbW)
  );

  strap_irq_dp #(
    .NUM_MODE(NUM_MODE), .SYNC_STAGES(SYNC_STAGES), .IRQ_IDX(1), .NMI_IDX(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .modePins(modePins),
    .pllInitPin(pllInitPin), .clkPolPin(clkPolPin),
    .irqEdgeMode(irqEdgeMode), .stb(stbW),
    .irqNow(irqNowW), .irqPrev(irqPrevW),
    .nmiNow(nmiNowW), .nmiPrev(nmiPrevW),
    .opMode(opMode), .pllEnable(pllEnable), .clkOutInvert(clkOutInvert),
    .irqReq(irqReq), .nmiReq(nmiReq)
  );
endmodule

// File: rtl/strap_irq_chk.sv
module strap_irq_chk
  import strap_irq_pkg::*;
#(
  parameter int NUM_MODE = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                armed,
  input ctrlStb_t            stb,
  input logic [NUM_MODE-1:0] opMode,
  input logic                pllEnable,
  input logic                clkOutInvert,
  input logic                irqEdgeMode,
  input logic                nmiClr,
  input logic                irqReq,
  input logic                nmiReq
);
  // R4
  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      quiet_in_reset_chk: assert (!irqReq && !nmiReq && opMode == '0);
    end
  end

  // R3
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(armed)) |-> ($stable(opMode) && $stable(pllEnable) && $stable(clkOutInvert)));

  // R7
  level_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEdgeMode && !armed) |-> !irqReq);

  // R6
  irq_edge_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEdgeMode && $past(irqEdgeMode) && $rose(irqReq)) |-> $past(stb.irqSet));

  // R8
  nmi_edge_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiReq) |-> $past(stb.nmiSet));

  // R8
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && !nmiClr) |=> nmiReq);

  // R9
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiClr && !stb.nmiSet) |=> !nmiReq);
endmodule

bind strap_irq_unit strap_irq_chk #(.NUM_MODE(NUM_MODE)) chk_i (
  .clk(clk), .rstN(rstN), .armed(armedW), .stb(stbW),
  .opMode(opMode), .pllEnable(pllEnable), .clkOutInvert(clkOutInvert),
  .irqEdgeMode(irqEdgeMode), .nmiClr(nmiClr),
  .irqReq(irqReq), .nmiReq(nmiReq)
);

// File: tb/strap_irq_unit_tb_top.sv
module strap_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modePins = 3'b111;
  logic pllInitPin = 1'b0, clkPolPin = 1'b0;
  logic irqEdgeMode = 1'b1, irqClr = 1'b0, nmiClr = 1'b0;
  logic [2:0] opMode;
  logic pllEnable, clkOutInvert, irqReq, nmiReq;
  int vecCount = 0, missCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strap_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .modePins(modePins),
    .pllInitPin(pllInitPin), .clkPolPin(clkPolPin),
    .irqEdgeMode(irqEdgeMode), .irqClr(irqClr), .nmiClr(nmiClr),
    .opMode(opMode), .pllEnable(pllEnable), .clkOutInvert(clkOutInvert),
    .irqReq(irqReq), .nmiReq(nmiReq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bootWith(input logic [2:0] m, input logic p, input logic c);
    rstN = 1'b0; modePins = m; pllInitPin = p; clkPolPin = c;
    irqClr = 1'b0; nmiClr = 1'b0;
    repeat (4) tick();
    check("R4 irq in reset", irqReq, 0);
    check("R4 nmi in reset", nmiReq, 0);
    check("R4 mode in reset", opMode, 0);
    rstN = 1'b1;
    tick();
    check("R1 mode capture", opMode, m);
    check("R2 straps capture", {pllEnable, clkOutInvert}, {p, c});
  endtask

  task automatic testResetToggle();
    rstN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      modePins = modePins ^ 3'b110;
      tick();
      check("R4 toggle in reset", {irqReq, nmiReq}, 0);
    end
  endtask

  task automatic testCaptureHold();
    bootWith(3'b101, 1'b1, 1'b0);
    modePins = 3'b010; pllInitPin = 1'b0; clkPolPin = 1'b1;
    repeat (4) tick();
    check("R3 mode held", opMode, 3'b101);
    check("R3 straps held", {pllEnable, clkOutInvert}, 2'b10);
    modePins = 3'b111;
    repeat (3) tick();
    bootWith(3'b010, 1'b0, 1'b1);
    modePins = 3'b111;
    repeat (3) tick();
  endtask

  task automatic testNoFalseEdge();
    irqEdgeMode = 1'b1;
    bootWith(3'b000, 1'b0, 1'b0);
    repeat (5) tick();
    check("R10 irq no false edge", irqReq, 0);
    check("R10 nmi no false edge", nmiReq, 0);
    modePins = 3'b111;
    repeat (3) tick();
    check("R10 rise makes no request", {irqReq, nmiReq}, 0);
  endtask

  task automatic testIrqEdge();
    irqEdgeMode = 1'b1;
    modePins[1] = 1'b0;
    tick(); check("R6 edge not yet (1)", irqReq, 0);
    tick(); check("R6 edge not yet (2)", irqReq, 0);
    tick(); check("R6 edge set", irqReq, 1);
    modePins[1] = 1'b1;
    repeat (3) tick();
    check("R6 edge sticky", irqReq, 1);
    irqClr = 1'b1; tick(); irqClr = 1'b0;
    check("R9 irq cleared", irqReq, 0);
  endtask

  task automatic testIrqLevel();
    irqEdgeMode = 1'b0;
    tick();
    check("R7 level idle", irqReq, 0);
    modePins[1] = 1'b0;
    tick(); check("R5 one stage only", irqReq, 0);
    tick(); check("R7 level active", irqReq, 1);
    modePins[1] = 1'b1;
    tick(); check("R7 level lag", irqReq, 1);
    tick(); check("R7 level released", irqReq, 0);
    irqEdgeMode = 1'b1;
  endtask

  task automatic testNmi();
    irqEdgeMode = 1'b0;
    modePins[2] = 1'b0;
    tick(); tick(); check("R8 nmi not yet", nmiReq, 0);
    tick(); check("R8 nmi set", nmiReq, 1);
    check("R8 no irq from C", irqReq, 0);
    modePins[2] = 1'b1;
    repeat (3) tick();
    check("R8 nmi sticky", nmiReq, 1);
    nmiClr = 1'b1; tick(); nmiClr = 1'b0;
    check("R9 nmi cleared", nmiReq, 0);
    irqEdgeMode = 1'b1;
  endtask

  task automatic testSetWins();
    nmiClr = 1'b1;
    modePins[2] = 1'b0;
    tick(); tick(); tick();
    check("R9 set beats clear", nmiReq, 1);
    nmiClr = 1'b0;
    modePins[2] = 1'b1;
    repeat (2) tick();
    check("R9 kept after clear drop", nmiReq, 1);
    nmiClr = 1'b1; tick(); nmiClr = 1'b0;
    check("R9 final clear", nmiReq, 0);
  endtask

  initial begin
    testResetToggle();
    bootWith(3'b111, 1'b1, 1'b1);
    testCaptureHold();
    testNoFalseEdge();
    testIrqEdge();
    testIrqLevel();
    testNmi();
    testSetWins();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      vecCount++;
      missCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule